// File: doc/BRIEF.md
# PHY test-port configuration sequencer

This block programs the timing and PLL registers of a display PHY through a narrow indirect test port and then powers the PHY up. A one-cycle start pulse launches a fixed programme. First the PHY is held in reset and the test port is cleared. Then every parameter of a small table is written. Finally the reset, shutdown and clock-enable lines are released in steps, and a status word is polled until the PHY reports it is ready or the allowed attempts run out.

The table holds address/value pairs in three groups: clock-lane timing, data-lane timing and configuration. The data-lane group is written once for every active lane. The lane index shifts the address by a fixed stride. Each pair goes out as two phases on the test port, and each phase is latched by its own strobe pulse. A prescaler sets how long every step on the test port lasts. The parameter values themselves are computed elsewhere and arrive as inputs.

Top module: `phy_cfg_seq`

## Requirements
- R1: After reset, the control word, the data bus, the three PHY lines, done and timeout are all 0.
- R2: Each start first drives the reset, shutdown-release and clock-enable lines low, then drives the control word 0, then 1, then 0 (value 1 held for one step) with the data bus at 0. This happens before any parameter write.
- R3: Each parameter write has two phases. In the address phase the data bus carries the address with bit 16 set. In the value phase it carries the value. In each phase the control word goes 0, then 2, then 0, and the data bus is steady for at least one step before the control word rises to 2.
- R4: Writes go in this order: table entries 0..4 (clock lane), then for each lane i from 0 upward entries 5..11 with address plus i*LANE_STRIDE, then entries 12..17 (configuration).
- R5: The lane count is taken at start. A value of 0 counts as 1, and values above MAX_LANES count as MAX_LANES.
- R6: Every step on the test port, including each strobe high, lasts presc+2 clock cycles, with presc taken at start.
- R7: Clock enable rises first. Shutdown release follows WAIT_SHORT cycles later, and reset release follows another WAIT_SHORT cycles later. Reset release is never high without the other two, and shutdown release is never high without clock enable.
- R8: The first status attempt comes WAIT_LONG cycles after reset release, and attempts are POLL_GAP cycles apart. An attempt succeeds when status bit 0 or bit 2 is set; other bits are ignored. Success ends the run with timeout 0.
- R9: After MAX_POLL failed attempts the run ends with timeout 1. Timeout then stays set until the next accepted start clears it.
- R10: done is high for exactly one cycle at the end of each completed run, in the cycle after the deciding attempt.
- R11: A start pulse during a run is ignored. The run goes on unchanged and finishes once.
- R12: A shut_req pulse drives all three PHY lines and the control word to 0 in the next cycle, aborts any run in progress and gives no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse launching the programme |
| shut_req | input | 1 | One-cycle pulse that powers the PHY down |
| lanes | input | LN_W | Active data lanes (clamped to 1..MAX_LANES) |
| presc | input | PRESC_W | Step-length prescaler |
| tbl_addr | input | N_ENT*ADDR_W | Packed register addresses, entry 0 in the low bits |
| tbl_val | input | N_ENT*VAL_W | Packed register values, entry 0 in the low bits |
| phy_stat | input | STAT_W | PHY status word |
| tp_ctrl | output | 2 | Test-port control word |
| tp_data | output | BUS_W | Test-port data bus |
| phy_rstz | output | 1 | PHY reset release |
| phy_unshut | output | 1 | PHY shutdown release |
| phy_clken | output | 1 | PHY clock enable |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout | output | 1 | Status poll ran out of attempts |

## Verification
The properties assume that start and shut_req are single-cycle pulses, and that the strobe-width property does not hold in a cycle where shut_req cuts a strobe short. The bench pulses both controls for exactly one cycle and raises shut_req only once the test port is idle or partway through a run. It lets the status model answer only after reset release, with a bit pattern and delay drawn from a fixed-seed generator. Lane counts outside 1..4 and prescaler values 0..3 are drawn the same way, so the clamp and step-width rules are exercised without leaving the documented input ranges.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CLR, ST_WR, ST_PW1, ST_PW2, ST_PW3, ST_POLL
   } seq_st_e;

   typedef enum logic [1:0] {
      GR_CLK, GR_LANE, GR_CFG
   } grp_e;

   localparam logic [1:0] TP_REST  = 2'd0;
   localparam logic [1:0] TP_CLEAR = 2'd1;
   localparam logic [1:0] TP_STB   = 2'd2;
   localparam int         FLAG_BIT = 16;
endpackage

// File: rtl/phy_cfg_tmr.sv
module phy_cfg_tmr #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] ld_val,
   output logic          zero
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= ld_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/phy_cfg_item.sv
module phy_cfg_item
   import phy_cfg_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int VAL_W       = 8,
   parameter int N_CLK       = 5,
   parameter int N_LANE      = 7,
   parameter int N_CFG       = 6,
   parameter int IDX_W       = 3,
   parameter int LN_W        = 3,
   parameter int LANE_STRIDE = 64,
   localparam int N_ENT      = N_CLK + N_LANE + N_CFG,
   localparam int EW         = $clog2(N_ENT)
) (
   input  grp_e                    grp,
   input  logic [IDX_W-1:0]        idx,
   input  logic [LN_W-1:0]         lane,
   input  logic [N_ENT*ADDR_W-1:0] tbl_addr,
   input  logic [N_ENT*VAL_W-1:0]  tbl_val,
   output logic [ADDR_W-1:0]       addr,
   output logic [VAL_W-1:0]        val,
   output logic                    last
);
   logic [ADDR_W-1:0] ta [N_ENT];
   logic [VAL_W-1:0]  tv [N_ENT];

   for (genvar g = 0; g < N_ENT; g++) begin : g_unpack
      assign ta[g] = tbl_addr[g*ADDR_W +: ADDR_W];
      assign tv[g] = tbl_val[g*VAL_W +: VAL_W];
   end

   logic [EW-1:0]     ent;
   logic [ADDR_W-1:0] lane_off;

   always_comb begin
      unique case (grp)
         GR_CLK:  begin ent = EW'(idx);                  last = (idx == IDX_W'(N_CLK - 1));  end
         GR_LANE: begin ent = EW'(idx) + EW'(N_CLK);     last = (idx == IDX_W'(N_LANE - 1)); end
         default: begin ent = EW'(idx) + EW'(N_CLK + N_LANE); last = (idx == IDX_W'(N_CFG - 1)); end
      endcase
      lane_off = (grp == GR_LANE) ? ADDR_W'(lane) * ADDR_W'(LANE_STRIDE) : '0;
      addr     = ta[ent] + lane_off;
      val      = tv[ent];
   end
endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
   import phy_cfg_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int VAL_W       = 8,
   parameter int BUS_W       = 32,
   parameter int PRESC_W     = 4,
   parameter int MAX_LANES   = 4,
   parameter int N_CLK       = 5,
   parameter int N_LANE      = 7,
   parameter int N_CFG       = 6,
   parameter int LANE_STRIDE = 64,
   parameter int WAIT_SHORT  = 100,
   parameter int WAIT_LONG   = 100000,
   parameter int POLL_GAP    = 100,
   parameter int MAX_POLL    = 100,
   parameter int STAT_W      = 8,
   parameter logic [STAT_W-1:0] HIT_MASK = STAT_W'(5),
   localparam int N_ENT      = N_CLK + N_LANE + N_CFG,
   localparam int LN_W       = $clog2(MAX_LANES + 1),
   localparam int GMAX       = (N_CLK > N_LANE) ? ((N_CLK > N_CFG) ? N_CLK : N_CFG)
                                                : ((N_LANE > N_CFG) ? N_LANE : N_CFG),
   localparam int IDX_W      = $clog2(GMAX),
   localparam int TMAX_A     = (WAIT_LONG > WAIT_SHORT) ? WAIT_LONG : WAIT_SHORT,
   localparam int TMAX_B     = (TMAX_A > POLL_GAP) ? TMAX_A : POLL_GAP,
   localparam int TMAX       = (TMAX_B > (1 << PRESC_W) + 1) ? TMAX_B : (1 << PRESC_W) + 1,
   localparam int TW         = $clog2(TMAX + 1),
   localparam int PW         = $clog2(MAX_POLL + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    shut_req,
   input  logic [LN_W-1:0]         lanes,
   input  logic [PRESC_W-1:0]      presc,
   input  logic [N_ENT*ADDR_W-1:0] tbl_addr,
   input  logic [N_ENT*VAL_W-1:0]  tbl_val,
   input  logic [STAT_W-1:0]       phy_stat,
   output logic [1:0]              tp_ctrl,
   output logic [BUS_W-1:0]        tp_data,
   output logic                    phy_rstz,
   output logic                    phy_unshut,
   output logic                    phy_clken,
   output logic                    done,
   output logic                    timeout
);
   if (BUS_W <= FLAG_BIT)       begin : g_bad_bus  $error("BUS_W must exceed the flag bit"); end
   if (ADDR_W > FLAG_BIT)       begin : g_bad_addr $error("ADDR_W must stay below the flag bit"); end
   if (VAL_W > BUS_W)           begin : g_bad_val  $error("VAL_W wider than the bus"); end
   if (WAIT_SHORT < 1 || WAIT_LONG < 1 || POLL_GAP < 1 || MAX_POLL < 1)
                                begin : g_bad_wait $error("waits and poll count must be positive"); end

   localparam logic [BUS_W-1:0] FLAG = BUS_W'(1) << FLAG_BIT;

   seq_st_e           st;
   grp_e              grp;
   logic [2:0]        beat;
   logic [IDX_W-1:0]  idx;
   logic [LN_W-1:0]   lane, nl;
   logic [PRESC_W-1:0] presc_q;
   logic [2:0]        lines;   // {rstz, unshut, clken}
   logic [PW-1:0]     att;
   logic              tz, ld;
   logic [TW-1:0]     ldv, beat_len;
   logic [ADDR_W-1:0] it_addr;
   logic [VAL_W-1:0]  it_val;
   logic              it_last, wr_fin, hit;
   logic [LN_W-1:0]   lanes_eff;

   // lane-count clamp; a single-lane build needs no compare logic
   if (MAX_LANES == 1) begin : g_one_lane
      assign lanes_eff = LN_W'(1);
   end else begin : g_clamp
      assign lanes_eff = (lanes == '0) ? LN_W'(1) :
                         (lanes > LN_W'(MAX_LANES)) ? LN_W'(MAX_LANES) : lanes;
   end

   phy_cfg_tmr #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(ld), .ld_val(ldv), .zero(tz)
   );

   phy_cfg_item #(
      .ADDR_W(ADDR_W), .VAL_W(VAL_W), .N_CLK(N_CLK), .N_LANE(N_LANE), .N_CFG(N_CFG),
      .IDX_W(IDX_W), .LN_W(LN_W), .LANE_STRIDE(LANE_STRIDE)
   ) u_item (
      .grp(grp), .idx(idx), .lane(lane), .tbl_addr(tbl_addr), .tbl_val(tbl_val),
      .addr(it_addr), .val(it_val), .last(it_last)
   );

   assign beat_len = TW'(presc_q) + TW'(1);
   assign wr_fin   = (beat == 3'd5) && it_last && (grp == GR_CFG);
   assign hit      = |(phy_stat & HIT_MASK);

   always_comb begin
      ld  = 1'b0;
      ldv = '0;
      case (st)
         ST_IDLE: if (start) begin ld = 1'b1; ldv = TW'(presc) + TW'(1); end
         ST_CLR:  if (tz) begin ld = 1'b1; ldv = beat_len; end
         ST_WR:   if (tz) begin ld = 1'b1; ldv = wr_fin ? TW'(WAIT_SHORT - 1) : beat_len; end
         ST_PW1:  if (tz) begin ld = 1'b1; ldv = TW'(WAIT_SHORT - 1); end
         ST_PW2:  if (tz) begin ld = 1'b1; ldv = TW'(WAIT_LONG - 1); end
         ST_PW3:  if (tz) begin ld = 1'b1; ldv = '0; end
         ST_POLL: if (tz) begin ld = 1'b1; ldv = TW'(POLL_GAP - 1); end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; grp <= GR_CLK; beat <= '0; idx <= '0; lane <= '0;
         nl <= LN_W'(1); presc_q <= '0; lines <= '0; att <= '0;
         done <= 1'b0; timeout <= 1'b0;
      end else begin
         done <= 1'b0;
         if (shut_req) begin
            st    <= ST_IDLE;
            lines <= '0;
         end else begin
            case (st)
               ST_IDLE: if (start) begin
                  st <= ST_CLR; beat <= '0; lines <= '0; timeout <= 1'b0;
                  nl <= lanes_eff; presc_q <= presc;
               end
               ST_CLR: if (tz) begin
                  if (beat == 3'd2) begin
                     st <= ST_WR; beat <= '0; grp <= GR_CLK; idx <= '0; lane <= '0;
                  end else beat <= beat + 3'd1;
               end
               ST_WR: if (tz) begin
                  if (beat != 3'd5) beat <= beat + 3'd1;
                  else begin
                     beat <= '0;
                     if (!it_last) idx <= idx + 1'b1;
                     else begin
                        idx <= '0;
                        case (grp)
                           GR_CLK:  grp <= GR_LANE;
                           GR_LANE: if (lane == nl - 1'b1) grp <= GR_CFG;
                                    else lane <= lane + 1'b1;
                           default: begin st <= ST_PW1; lines <= 3'b001; end
                        endcase
                     end
                  end
               end
               ST_PW1: if (tz) begin st <= ST_PW2; lines <= 3'b011; end
               ST_PW2: if (tz) begin st <= ST_PW3; lines <= 3'b111; end
               ST_PW3: if (tz) begin st <= ST_POLL; att <= '0; end
               ST_POLL: if (tz) begin
                  if (hit) begin
                     done <= 1'b1; st <= ST_IDLE;
                  end else if (att == PW'(MAX_POLL - 1)) begin
                     done <= 1'b1; timeout <= 1'b1; st <= ST_IDLE;
                  end else att <= att + 1'b1;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      tp_ctrl = TP_REST;
      tp_data = '0;
      if (st == ST_CLR) begin
         tp_ctrl = (beat == 3'd1) ? TP_CLEAR : TP_REST;
      end else if (st == ST_WR) begin
         tp_ctrl = (beat == 3'd1 || beat == 3'd4) ? TP_STB : TP_REST;
         tp_data = (beat < 3'd3) ? (FLAG | BUS_W'(it_addr)) : BUS_W'(it_val);
      end
   end

   assign phy_clken  = lines[0];
   assign phy_unshut = lines[1];
   assign phy_rstz   = lines[2];
endmodule

// File: rtl/phy_cfg_seq_chk.sv
module phy_cfg_seq_chk #(
   parameter int BUS_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             shut_req,
   input logic [1:0]       tp_ctrl,
   input logic [BUS_W-1:0] tp_data,
   input logic             phy_rstz,
   input logic             phy_unshut,
   input logic             phy_clken,
   input logic             done,
   input logic             timeout
);
   assert_no_ctrl3_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tp_ctrl != 2'b11);

   assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tp_ctrl[1]) |-> $stable(tp_data));

   assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tp_ctrl[1]) && !shut_req) |=> tp_ctrl[1]);

   assert_port_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tp_ctrl != 2'b00) |-> (!phy_rstz && !phy_unshut && !phy_clken));

   assert_rstz_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rstz |-> (phy_unshut && phy_clken));

   assert_unshut_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      phy_unshut |-> phy_clken);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_timeout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !start) |=> timeout);

   assert_shutdown_R12: assert property (@(posedge clk) disable iff (!rst_n)
      shut_req |=> (!phy_rstz && !phy_unshut && !phy_clken && tp_ctrl == 2'b00 && !done));
endmodule

bind phy_cfg_seq phy_cfg_seq_chk #(.BUS_W(BUS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .shut_req(shut_req),
   .tp_ctrl(tp_ctrl), .tp_data(tp_data), .phy_rstz(phy_rstz),
   .phy_unshut(phy_unshut), .phy_clken(phy_clken), .done(done), .timeout(timeout)
);

// File: tb/phy_cfg_seq_tb.sv
module phy_cfg_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WS = 4, WL = 20, GAP = 3, MAXP = 100;
   localparam int NENT = 18, STRIDE = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, shut_req = 1'b0;
   logic [2:0] lanes = 3'd1;
   logic [3:0] presc = '0;
   logic [NENT*8-1:0] tbl_addr, tbl_val;
   logic [7:0] phy_stat = '0;
   logic [1:0] tp_ctrl;
   logic [31:0] tp_data;
   logic phy_rstz, phy_unshut, phy_clken, done, timeout;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_cfg_seq #(.WAIT_SHORT(WS), .WAIT_LONG(WL), .POLL_GAP(GAP), .MAX_POLL(MAXP),
                 .LANE_STRIDE(STRIDE)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .shut_req(shut_req), .lanes(lanes),
      .presc(presc), .tbl_addr(tbl_addr), .tbl_val(tbl_val), .phy_stat(phy_stat),
      .tp_ctrl(tp_ctrl), .tp_data(tp_data), .phy_rstz(phy_rstz), .phy_unshut(phy_unshut),
      .phy_clken(phy_clken), .done(done), .timeout(timeout));

   int nvec = 0, nfail = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor and PHY status model
   int nwr, stb_t, stb_min, stb_max, clr_cnt, clken_cyc, unshut_cyc, rstz_cyc;
   int done_cnt, done_cyc, stat_delay;
   bit clr_bad, phase_bad, have_addr, done_tmo;
   logic [7:0] stat_mode = '0;
   logic [15:0] cur_addr;
   logic [15:0] wa [64];
   logic [7:0]  wv [64];
   logic [1:0]  prev_ctrl = '0;
   logic [2:0]  prev_lines = '0;

   task automatic clear_log();
      nwr = 0; stb_min = 1 << 20; stb_max = 0; clr_cnt = 0; clr_bad = 0; phase_bad = 0;
      have_addr = 0; clken_cyc = -1; unshut_cyc = -1; rstz_cyc = -1;
      done_cnt = 0; done_cyc = -1; done_tmo = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (tp_ctrl == 2'd1) begin
            clr_cnt++;
            if (phy_clken || phy_unshut || phy_rstz || tp_data != 0 || nwr > 0) clr_bad = 1;
         end
         if (tp_ctrl == 2'd2 && prev_ctrl != 2'd2) begin
            stb_t = cyc;
            if (tp_data[16]) begin
               cur_addr = tp_data[15:0]; have_addr = 1;
               if (tp_data[31:17] != 0) phase_bad = 1;
            end else begin
               if (!have_addr) phase_bad = 1;
               else if (nwr < 64) begin wa[nwr] = cur_addr; wv[nwr] = tp_data[7:0]; end
               nwr++; have_addr = 0;
            end
         end
         if (tp_ctrl != 2'd2 && prev_ctrl == 2'd2) begin
            if (cyc - stb_t < stb_min) stb_min = cyc - stb_t;
            if (cyc - stb_t > stb_max) stb_max = cyc - stb_t;
         end
         if (phy_clken && !prev_lines[0]) clken_cyc = cyc;
         if (phy_unshut && !prev_lines[1]) unshut_cyc = cyc;
         if (phy_rstz && !prev_lines[2]) rstz_cyc = cyc;
         if (done) begin done_cnt++; done_cyc = cyc; done_tmo = timeout; end
         phy_stat = (phy_rstz && rstz_cyc >= 0 && cyc - rstz_cyc >= stat_delay) ? stat_mode : 8'h00;
         prev_ctrl = tp_ctrl;
         prev_lines = {phy_rstz, phy_unshut, phy_clken};
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int clampl(input int ln);
      return (ln == 0) ? 1 : (ln > 4) ? 4 : ln;
   endfunction

   // table entry and lane for write number k
   function automatic int ent_of(input int k, input int nl);
      if (k < 5) return k;
      if (k < 5 + 7*nl) return 5 + (k - 5) % 7;
      return 12 + (k - 5 - 7*nl);
   endfunction

   function automatic int lane_of(input int k, input int nl);
      if (k >= 5 && k < 5 + 7*nl) return (k - 5) / 7;
      return 0;
   endfunction

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   endtask

   task automatic run_one(input int ln, input int ps, input logic [7:0] smode,
                          input int sdel, input bit extra_start);
      int nl, guard, bad, hit_k, exp_done;
      bit exp_tmo;
      nl = clampl(ln);
      lanes = 3'(ln); presc = 4'(ps); stat_mode = smode; stat_delay = sdel;
      for (int e = 0; e < NENT; e++) tbl_val[e*8 +: 8] = 8'($urandom);
      @(negedge clk);
      clear_log();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(timeout == 1'b0, "R9", "timeout cleared by start", timeout, 0);
      if (extra_start) begin
         repeat (50) @(negedge clk);
         lanes = 3'(nl == 1 ? 3 : 1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (done_cnt == 0 && guard < 20000) begin @(negedge clk); guard++; end
      repeat (6) @(negedge clk);
      chk(nwr == 5 + 7*nl + 6, extra_start ? "R11" : "R4/R5", "write count", nwr, 5 + 7*nl + 6);
      bad = 0;
      for (int k = 0; k < nwr && k < 64; k++) begin
         int e = ent_of(k, nl);
         logic [15:0] ea = 16'(8'(tbl_addr[e*8 +: 8] + 8'(lane_of(k, nl) * STRIDE)));
         if (wa[k] !== ea || wv[k] !== tbl_val[e*8 +: 8]) bad++;
      end
      chk(bad == 0, "R4", "address/value pairs out of order", bad, 0);
      chk(!phase_bad, "R3", "address phase before value phase", phase_bad, 0);
      chk(stb_min == ps + 2 && stb_max == ps + 2, "R6", "strobe width", stb_max, ps + 2);
      chk(clr_cnt == ps + 2 && !clr_bad, "R2", "clear step", clr_cnt, ps + 2);
      chk(unshut_cyc - clken_cyc == WS && rstz_cyc - unshut_cyc == WS, "R7",
          "release gaps", rstz_cyc - clken_cyc, 2*WS);
      hit_k = -1;
      for (int k = 1; k <= MAXP; k++) begin
         int a = WL + (k - 1)*GAP;
         if (hit_k < 0 && (smode & 8'h05) != 0 && a >= sdel) hit_k = k;
      end
      exp_tmo = (hit_k < 0);
      exp_done = rstz_cyc + WL + (exp_tmo ? (MAXP - 1) : (hit_k - 1))*GAP + 1;
      chk(done_cyc == exp_done, exp_tmo ? "R9" : "R8", "done cycle", done_cyc, exp_done);
      chk(done_tmo == exp_tmo, exp_tmo ? "R9" : "R8", "timeout flag", done_tmo, exp_tmo);
      chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      nfail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'd7321));
      for (int e = 0; e < NENT; e++) begin
         tbl_addr[e*8 +: 8] = 8'(e*3 + 1);
         tbl_val[e*8 +: 8] = '0;
      end
      clear_log();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tp_ctrl == 0 && tp_data == 0 && {phy_rstz, phy_unshut, phy_clken} == 0 &&
          !done && !timeout, "R1", "reset state", {tp_ctrl, phy_rstz, phy_unshut, phy_clken, done, timeout}, 0);

      run_one(4, 0, 8'h01, 0, 0);
      run_one(1, 3, 8'h04, 40, 1);
      run_one(0, 1, 8'h02, 0, 0);
      repeat (10) @(negedge clk);
      chk(timeout == 1'b1, "R9", "timeout held", timeout, 1);
      run_one(7, 2, 8'h05, 100, 0);

      // shut down a running PHY
      shut_req = 1'b1;
      @(negedge clk);
      shut_req = 1'b0;
      chk({phy_rstz, phy_unshut, phy_clken} == 0, "R12", "lines after shutdown",
          {phy_rstz, phy_unshut, phy_clken}, 0);

      // abort a run partway
      clear_log();
      lanes = 3'd2; presc = 4'd1;
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (60) @(negedge clk);
      shut_req = 1'b1; @(negedge clk); shut_req = 1'b0;
      chk(tp_ctrl == 0 && {phy_rstz, phy_unshut, phy_clken} == 0, "R12", "port after abort",
          tp_ctrl, 0);
      repeat (300) @(negedge clk);
      chk(done_cnt == 0 && tp_ctrl == 0, "R12", "no done after abort", done_cnt, 0);

      for (int r = 0; r < 6; r++) begin
         logic [7:0] modes [5] = '{8'h01, 8'h04, 8'h05, 8'h02, 8'h00};
         run_one(int'($urandom % 8), int'($urandom % 4), modes[$urandom % 5],
                 int'($urandom % 60), 1'b0);
      end
      summary();
   end
endmodule